// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock and Quick-Lock Control

This block sits between the two divider chains of a frequency synthesizer and the analog pump. It samples the divided VCO pulse and the divided reference pulse on a system clock and finds their rising edges. From the order and spacing of those edges it builds pump-up and pump-down commands. A drive-enable tells the pump when to drive; when it is deasserted, the pump output floats. Every completed comparison yields an error length in system clocks. The block tests that length against a programmable tolerance window.

Two controls ride on the window test. The lock flag rises after a run of in-window comparisons, falls on the first comparison outside the window, and is forced low by an enable bit. The quick-lock enable arms when the operate input rises. While armed, it follows the main drive to double the pump current. It releases on the first in-window comparison and stays released until operate rises again. With operate low, the block is in standby: the detector, the error counter and the lock state are cleared, and all drive outputs stay off.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: `pump_up` and `pump_dn` are never high together, and `drive_en` is high exactly when one of them is high.
- R2: A rising edge on `ref_pulse` that leads a rising edge on `vco_pulse` by d clocks makes `pump_up` high for exactly d consecutive clocks. Its first high clock comes two clock edges after the edge on the input. The mirrored case drives `pump_dn` in the same way. Edges in the same clock give no pump command.
- R3: The error of a comparison is the number of clocks its pump command was high (0 for coincident edges). The comparison is inside the window when that error is less than or equal to `win_cycles`.
- R4: `lock_flag` goes high on the fourth consecutive in-window comparison. It goes low on the first comparison outside the window.
- R5: While `lock_en` is low, `lock_flag` is low from the next clock on. The lock history is still kept, so the flag reappears once `lock_en` is high again and a comparison completes inside the window.
- R6: `quick_en` arms when `operate` rises, which includes the first clock after reset if `operate` is high. While armed, it is high in exactly the clocks in which `drive_en` is high. It releases at the first in-window comparison.
- R7: After release, `quick_en` stays low through any number of comparisons, whether inside or outside the window, until `operate` rises again.
- R8: While `operate` is low, from the next clock on `pump_up`, `pump_dn`, `drive_en`, `quick_en` and `lock_flag` are low. A pending pump command and the lock run are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| operate | input | 1 | High for normal operation, low for standby |
| lock_en | input | 1 | Enables the lock flag output |
| win_cycles | input | ERR_W | Tolerance window in system clocks |
| ref_pulse | input | 1 | Divided reference pulse |
| vco_pulse | input | 1 | Divided VCO pulse |
| pump_up | output | 1 | Pump-up command (reference leads) |
| pump_dn | output | 1 | Pump-down command (VCO leads) |
| drive_en | output | 1 | Main pump drives when high, floats when low |
| quick_en | output | 1 | Quick-lock pump drives when high, floats when low |
| lock_flag | output | 1 | Loop locked |

## Verification
The bench sweeps the edge offset on both sides of the window boundary, in both lead directions, and includes coincident edges. A detector that is off by one clock in its latency or in its error count misjudges the comparison at exactly the window boundary, and its lock run then departs from the arithmetic model. Runs of three and four in-window comparisons, each broken by a single out-of-window one, catch a lock counter with the wrong threshold or one that does not clear. The bench also checks that quick-lock stays released after an out-of-window comparison and re-arms only on an operate rise. A standby entered while a pump command is pending must discard that command; a design that kept it would emit a stray pulse or a false lock once operation resumes.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [0:0] {
    LK_HUNT = 1'b0,
    LK_HOLD = 1'b1
  } lock_state_e;

  localparam int unsigned LOCK_RUN_DEF = 4;
  localparam int unsigned ERR_W_DEF    = 8;
endpackage

// File: rtl/pfd_edge_detect.sv
module pfd_edge_detect #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh[0] <= 1'b0;
    else     sh[0] <= sig_in;
  end

  genvar gi;
  generate
    for (gi = 1; gi <= LAST; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sh[gi] <= 1'b0;
        else     sh[gi] <= sh[gi-1];
      end
    end
  endgenerate

  assign rise = sh[LAST-1] & ~sh[LAST];
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ref_rise,
  input  logic             vco_rise,
  output logic             up_q,
  output logic             dn_q,
  output logic             cmp_valid,
  output logic [ERR_W-1:0] cmp_err
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic [ERR_W-1:0] cnt;
  logic [ERR_W-1:0] cnt_inc;
  logic             want_up;
  logic             want_dn;
  logic             both;
  logic             pending;

  always_comb begin
    want_up = up_q | ref_rise;
    want_dn = dn_q | vco_rise;
    both    = want_up & want_dn;
    pending = up_q | dn_q;
    cnt_inc = (cnt == ERR_MAX) ? cnt : cnt + 1'b1;
  end

  assign cmp_valid = run & both;
  assign cmp_err   = pending ? cnt_inc : '0;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
      cnt  <= '0;
    end else if (both) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
      cnt  <= '0;
    end else begin
      up_q <= want_up;
      dn_q <= want_dn;
      cnt  <= pending ? cnt_inc : '0;
    end
  end
endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon
  import pfd_pkg::*;
#(
  parameter int unsigned ERR_W    = 8,
  parameter int unsigned LOCK_RUN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             lock_en,
  input  logic [ERR_W-1:0] win_cycles,
  input  logic             cmp_valid,
  input  logic [ERR_W-1:0] cmp_err,
  output logic             lock_flag,
  output logic             quick_q
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_RUN);

  lock_state_e      state, state_n;
  logic [RUN_W-1:0] good, good_n;
  logic             in_win;
  logic             run_prev;

  always_comb begin
    in_win  = (cmp_err <= win_cycles);
    state_n = state;
    good_n  = good;
    if (cmp_valid) begin
      if (in_win) begin
        good_n  = (good == RUN_TOP) ? good : good + 1'b1;
        state_n = (good_n == RUN_TOP) ? LK_HOLD : LK_HUNT;
      end else begin
        good_n  = '0;
        state_n = LK_HUNT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_prev  <= 1'b0;
      state     <= LK_HUNT;
      good      <= '0;
      lock_flag <= 1'b0;
      quick_q   <= 1'b0;
    end else begin
      run_prev <= run;
      if (!run) begin
        state     <= LK_HUNT;
        good      <= '0;
        lock_flag <= 1'b0;
        quick_q   <= 1'b0;
      end else begin
        state     <= state_n;
        good      <= good_n;
        lock_flag <= lock_en && (state_n == LK_HOLD);
        if (!run_prev)
          quick_q <= 1'b1;
        if (cmp_valid && in_win)
          quick_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl
  import pfd_pkg::*;
#(
  parameter int unsigned ERR_W       = ERR_W_DEF,
  parameter int unsigned LOCK_RUN    = LOCK_RUN_DEF,
  parameter int unsigned SYNC_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             operate,
  input  logic             lock_en,
  input  logic [ERR_W-1:0] win_cycles,
  input  logic             ref_pulse,
  input  logic             vco_pulse,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             drive_en,
  output logic             quick_en,
  output logic             lock_flag
);
  logic             ref_rise;
  logic             vco_rise;
  logic             up_q;
  logic             dn_q;
  logic             cmp_valid;
  logic [ERR_W-1:0] cmp_err;
  logic             quick_q;

  pfd_edge_detect #(.STAGES(SYNC_STAGES)) u_ref_edge (
    .clk(clk), .rst(rst), .sig_in(ref_pulse), .rise(ref_rise)
  );

  pfd_edge_detect #(.STAGES(SYNC_STAGES)) u_vco_edge (
    .clk(clk), .rst(rst), .sig_in(vco_pulse), .rise(vco_rise)
  );

  pfd_core #(.ERR_W(ERR_W)) u_core (
    .clk(clk), .rst(rst), .run(operate),
    .ref_rise(ref_rise), .vco_rise(vco_rise),
    .up_q(up_q), .dn_q(dn_q),
    .cmp_valid(cmp_valid), .cmp_err(cmp_err)
  );

  pfd_lock_mon #(.ERR_W(ERR_W), .LOCK_RUN(LOCK_RUN)) u_lock (
    .clk(clk), .rst(rst), .run(operate), .lock_en(lock_en),
    .win_cycles(win_cycles), .cmp_valid(cmp_valid), .cmp_err(cmp_err),
    .lock_flag(lock_flag), .quick_q(quick_q)
  );

  assign pump_up  = up_q;
  assign pump_dn  = dn_q;
  assign drive_en = up_q | dn_q;
  assign quick_en = quick_q & (up_q | dn_q);
endmodule

// File: rtl/pfd_lock_ctrl_chk.sv
module pfd_lock_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic operate,
  input logic lock_en,
  input logic pump_up,
  input logic pump_dn,
  input logic drive_en,
  input logic quick_en,
  input logic lock_flag
);
  p_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(pump_up && pump_dn));

  p_ldmask_r5: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> !lock_flag);

  p_ldrise_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_flag) |-> $past(lock_en));

  p_quickhold_r6: assert property (@(posedge clk) disable iff (rst)
    operate && $past(operate) && drive_en && $past(drive_en)
      |-> quick_en == $past(quick_en));

  p_standby_r8: assert property (@(posedge clk) disable iff (rst)
    !operate |=> !pump_up && !pump_dn && !quick_en && !lock_flag);
endmodule

bind pfd_lock_ctrl pfd_lock_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .operate(operate), .lock_en(lock_en),
  .pump_up(pump_up), .pump_dn(pump_dn), .drive_en(drive_en),
  .quick_en(quick_en), .lock_flag(lock_flag)
);

// File: tb/pfd_lock_ctrl_test.sv
module pfd_lock_ctrl_test;
  localparam int ERR_W = 8;
  localparam int WIN   = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             operate = 1'b1;
  logic             lock_en = 1'b1;
  logic [ERR_W-1:0] win_cycles = ERR_W'(WIN);
  logic             ref_pulse = 1'b0;
  logic             vco_pulse = 1'b0;
  logic             pump_up, pump_dn, drive_en, quick_en, lock_flag;

  int n_checks = 0;
  int n_fail   = 0;
  int good_m   = 0;
  bit lock_m   = 0;
  bit armed_m  = 1;

  always #10 clk = ~clk;

  pfd_lock_ctrl uut (
    .clk(clk), .rst(rst), .operate(operate), .lock_en(lock_en),
    .win_cycles(win_cycles), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
    .pump_up(pump_up), .pump_dn(pump_dn), .drive_en(drive_en),
    .quick_en(quick_en), .lock_flag(lock_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // one comparison: leader pulse, follower d clocks later
  task automatic compare(input bit ref_leads, input int d);
    int up_n = 0, dn_n = 0, q_n = 0, both_n = 0, drv_bad = 0;
    int first_up = -1;
    bit in_win;
    for (int i = 0; i < d + 7; i++) begin
      @(negedge clk);
      if (pump_up) begin up_n++; if (first_up < 0) first_up = i; end
      if (pump_dn) dn_n++;
      if (quick_en) q_n++;
      if (pump_up && pump_dn) both_n++;
      if (drive_en != (pump_up || pump_dn)) drv_bad++;
      ref_pulse = ref_leads ? (i == 0) : (i == d);
      vco_pulse = ref_leads ? (i == d) : (i == 0);
    end
    in_win = (d <= WIN);
    check("R1 exclusive", both_n, 0);
    check("R1 drive_en", drv_bad, 0);
    check("R2/R3 up length", up_n, ref_leads ? d : 0);
    check("R2/R3 dn length", dn_n, ref_leads ? 0 : d);
    if (ref_leads && d > 0) check("R2 latency", first_up, 2);
    check("R6 R7 quick length", q_n, armed_m ? d : 0);
    if (in_win) begin
      good_m = (good_m < 4) ? good_m + 1 : 4;
      lock_m = (good_m >= 4);
      armed_m = 0;
    end else begin
      good_m = 0;
      lock_m = 0;
    end
    check("R4 R5 lock", int'(lock_flag), int'(lock_m && lock_en));
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset up", int'(pump_up), 0);
    check("R8 reset quick", int'(quick_en), 0);
    check("R4 reset lock", int'(lock_flag), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R6: quick-lock armed, out-of-window keeps it, in-window releases it
    compare(1'b1, 5);
    compare(1'b0, 4);
    compare(1'b1, 2);
    // R2/R3/R4: sweep both directions across the window boundary
    for (int lead = 0; lead < 2; lead++)
      for (int d = 0; d < 7; d++)
        compare(lead[0], d);
    // R4: exactly three in-window then a break, then four
    for (int k = 0; k < 3; k++) compare(1'b1, 3);
    compare(1'b0, 4);
    for (int k = 0; k < 4; k++) compare(1'b0, 1);
    // R5: masked lock flag, history kept
    @(negedge clk) lock_en = 1'b0;
    @(negedge clk);
    check("R5 mask immediate", int'(lock_flag), 0);
    compare(1'b1, 2);
    compare(1'b0, 0);
    lock_en = 1'b1;
    compare(1'b1, 1);
    // R7: released quick-lock stays off after an out-of-window comparison
    compare(1'b1, 6);
    compare(1'b0, 5);
    for (int k = 0; k < 4; k++) compare(1'b1, 0);
    // R8: standby with a pending pump command
    @(negedge clk) ref_pulse = 1'b1;
    @(negedge clk) ref_pulse = 1'b0;
    @(negedge clk);
    check("R2 pending up", int'(pump_up), 1);
    operate = 1'b0;
    @(negedge clk);
    check("R8 standby up", int'(pump_up), 0);
    check("R8 standby drive", int'(drive_en), 0);
    check("R8 standby lock", int'(lock_flag), 0);
    @(negedge clk) vco_pulse = 1'b1;
    @(negedge clk) vco_pulse = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 standby dn", int'(pump_dn), 0);
    operate = 1'b1;
    good_m = 0; lock_m = 0; armed_m = 1;
    repeat (2) @(negedge clk);
    check("R8 no stray pulse", int'(drive_en), 0);
    // R7/R6: re-armed by the operate rise
    compare(1'b1, 4);
    compare(1'b0, 3);
    compare(1'b1, 2);
    report();
  end
endmodule